// File: doc/BRIEF.md
# Write Leveling Training Sequencer

This block steps a DDR3 channel through one write leveling pass for a chosen DIMM. A single start pulse captures the target DIMM index, a pass number and a table of rank counts for every DIMM slot. The block then issues mode register commands to every addressed rank. The target DIMM goes first. The other present DIMMs follow in ascending index order.

After this preparation the block waits a fixed gap and enables the on-die termination used for training. It waits for that termination to settle, then holds the PHY training enable high for a fixed window. It then removes training, removes the termination and waits again. Finally it walks the ranks a second time with normal-operation flags and signals completion with a one-cycle pulse.

The actual mode register values are built elsewhere. This block supplies only a flag set from which a value generator builds them:
- chip select
- mode register 1 or 2
- leveling bit
- output-off bit
- training-mode flag
- target flag

Top module: `wlvl_seq`

## Requirements
- R1: While reset is asserted and after it is released, cmd_valid_o, done_o, phy_odt_en_o and phy_train_en_o are all 0.
- R2: Each walk visits the target DIMM first and then the other DIMMs in ascending index order. A DIMM whose rank count is 0 is skipped. Ranks run from 0 upward. The chip select is 2 × DIMM index + rank.
- R3: For every rank, a mode register 1 command (cmd_mr2_o = 0) is issued first. A mode register 2 command (cmd_mr2_o = 1) for the same chip select follows it.
- R4: The leveling-walk flags are set as follows:
  - Every command of the first walk carries cmd_train_o = 1.
  - Mode register 1 for rank 0 of the target has cmd_level_o = 1 and cmd_qoff_o = 0.
  - Mode register 1 for any other target rank has cmd_level_o = 1 and cmd_qoff_o = 1.
  - Every non-target command and every mode register 2 command has both flags at 0.
  - cmd_target_o is 1 exactly for target-DIMM commands.
- R5: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and all command fields hold their values.
- R6: phy_odt_en_o rises 40 cycles after the clock edge that accepts the last leveling-walk command. If no DIMM is present, it rises 40 cycles after the edge that samples start_i.
- R7: phy_train_en_o rises 10 cycles after phy_odt_en_o rises. While it is high, phy_pass_o shows the pass number captured at start.
- R8: phy_train_en_o stays high for exactly 140 cycles. phy_odt_en_o falls one cycle after it.
- R9: No command is offered while phy_odt_en_o is high. The restore walk's first command appears 10 cycles after phy_odt_en_o falls. It follows the R2 order with cmd_train_o, cmd_level_o and cmd_qoff_o all 0.
- R10: done_o is high for exactly one cycle. It rises at the edge that accepts the last restore command, or 10 cycles after phy_odt_en_o falls if no DIMM is present.
- R11: A start_i pulse while a pass is in progress has no effect: no extra commands and no extra done pulse.
- R12: A rank count above 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a pass when the block is idle |
| tgt_dimm_i | input | 2 | Index of the DIMM to train, captured at start |
| pass_i | input | 2 | Pass number, captured at start |
| rank_cnt_i | input | 8 | Two bits per DIMM slot (slot d at bits 2d+1:2d), rank count, 0 = absent |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_valid_o | output | 1 | Mode register command offered |
| cmd_ready_i | input | 1 | Command accepted when high with cmd_valid_o |
| cmd_cs_o | output | 3 | Chip select of the command |
| cmd_mr2_o | output | 1 | 0 = mode register 1, 1 = mode register 2 |
| cmd_level_o | output | 1 | Leveling bit for the mode register 1 value |
| cmd_qoff_o | output | 1 | Output-off bit for the mode register 1 value |
| cmd_train_o | output | 1 | 1 = training-mode values, 0 = normal values |
| cmd_target_o | output | 1 | Command addresses the target DIMM |
| phy_odt_en_o | output | 1 | Training termination enable to the PHY |
| phy_train_en_o | output | 1 | PHY training engine enable |
| phy_pass_o | output | 2 | Captured pass number for the PHY |

## Verification
Each command is compared against the scoreboard on the clock edge that accepts it. Between acceptances, a stalled offer is checked at every following cycle for unchanged fields.

The bench records the edge of the last accepted leveling command, or of the start edge when nothing is present. From that edge it expects:
- termination to rise exactly 40 edges later;
- training enable to rise 10 edges after that and stay high for 140 edges;
- termination to drop one edge after training enable falls;
- the restore walk to begin 10 edges after that.

The done pulse is due on the edge that accepts the final restore command. All outputs are sampled on the falling clock, half a cycle after each of these edges, so each measured interval is an exact edge count.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

  localparam int RCNT_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK_LVL,
    ST_GAP_PREP,
    ST_ODT_SETTLE,
    ST_TRAIN,
    ST_TRAIN_OFF,
    ST_ODT_DRAIN,
    ST_WALK_NORM
  } seq_state_e;

  // Addressable ranks for a slot: counts beyond two are clipped.
  function automatic int unsigned eff_ranks(input logic [RCNT_W-1:0] c);
    return (c > 2'd2) ? 32'd2 : 32'(c);
  endfunction

  // Walk slot 0 is the target; later slots list the others in ascending order.
  function automatic int unsigned slot_to_dimm(input int unsigned slot,
                                               input int unsigned tgt);
    if (slot == 0) return tgt;
    if (slot - 1 < tgt) return slot - 1;
    return slot;
  endfunction

endpackage

// File: rtl/wlvl_timer.sv
module wlvl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6 R7 R8: every wait interval is one unbroken countdown
  p_tick_down_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/wlvl_walk.sv
module wlvl_walk
  import wlvl_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  parameter int DIMM_W    = $clog2(NUM_DIMMS),
  parameter int CS_W      = DIMM_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go_i,
  input  logic                        load_i,
  input  logic                        mode_i,
  input  logic [DIMM_W-1:0]           tgt_i,
  input  logic [NUM_DIMMS*RCNT_W-1:0] tbl_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic [CS_W-1:0]             cs_o,
  output logic                        mr2_o,
  output logic                        lvl_o,
  output logic                        qoff_o,
  output logic                        train_o,
  output logic                        tgt_hit_o,
  output logic                        fin_o,
  output logic                        empty_raw_o,
  output logic                        empty_lat_o
);

  localparam int SLOT_W = $clog2(NUM_DIMMS + 1);
  localparam int TBL_W  = NUM_DIMMS * RCNT_W;

  function automatic int unsigned cnt_of(input logic [TBL_W-1:0] tb,
                                         input int unsigned d);
    if (d >= NUM_DIMMS) return 0;
    return eff_ranks(tb[d*RCNT_W +: RCNT_W]);
  endfunction

  // First walk slot after 'from' that holds a present DIMM, NUM_DIMMS if none.
  function automatic int unsigned seek(input int from,
                                       input logic [TBL_W-1:0] tb,
                                       input int unsigned tg);
    int unsigned hit;
    hit = NUM_DIMMS;
    for (int j = NUM_DIMMS - 1; j >= 0; j--) begin
      if (j > from && cnt_of(tb, slot_to_dimm(32'(j), tg)) != 0) hit = 32'(j);
    end
    return hit;
  endfunction

  logic               active_q, rank_q, sel_q, mode_q;
  logic [SLOT_W-1:0]  slot_q;
  logic [DIMM_W-1:0]  tgt_q;
  logic [TBL_W-1:0]   tbl_q;

  logic [DIMM_W-1:0]  cur_dimm;
  int unsigned        nxt_slot, first_raw, first_lat, first_go;
  logic               last_rank, accept, last_cmd;

  always_comb begin
    cur_dimm  = DIMM_W'(slot_to_dimm(32'(slot_q), 32'(tgt_q)));
    nxt_slot  = seek(int'(32'(slot_q)), tbl_q, 32'(tgt_q));
    first_raw = seek(-1, tbl_i, 32'(tgt_i));
    first_lat = seek(-1, tbl_q, 32'(tgt_q));
    first_go  = load_i ? first_raw : first_lat;
    last_rank = (32'(rank_q) + 32'd1) >= cnt_of(tbl_q, 32'(cur_dimm));
  end

  assign accept   = active_q && ready_i;
  assign last_cmd = accept && sel_q && last_rank && (nxt_slot == NUM_DIMMS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      rank_q   <= 1'b0;
      sel_q    <= 1'b0;
      mode_q   <= 1'b0;
      tgt_q    <= '0;
      tbl_q    <= '0;
    end else begin
      if (load_i) begin
        tgt_q <= tgt_i;
        tbl_q <= tbl_i;
      end
      if (go_i) begin
        active_q <= (first_go != NUM_DIMMS);
        slot_q   <= SLOT_W'(first_go);
        rank_q   <= 1'b0;
        sel_q    <= 1'b0;
        mode_q   <= mode_i;
      end else if (accept) begin
        if (!sel_q) begin
          sel_q <= 1'b1;
        end else begin
          sel_q <= 1'b0;
          if (!last_rank) begin
            rank_q <= 1'b1;
          end else if (nxt_slot == NUM_DIMMS) begin
            active_q <= 1'b0;
          end else begin
            slot_q <= SLOT_W'(nxt_slot);
            rank_q <= 1'b0;
          end
        end
      end
    end
  end

  assign valid_o     = active_q;
  assign cs_o        = {cur_dimm, rank_q};
  assign mr2_o       = sel_q;
  assign tgt_hit_o   = (slot_q == '0);
  assign lvl_o       = mode_q && tgt_hit_o && !sel_q;
  assign qoff_o      = lvl_o && rank_q;
  assign train_o     = mode_q;
  assign fin_o       = last_cmd;
  assign empty_raw_o = (first_raw == NUM_DIMMS);
  assign empty_lat_o = (first_lat == NUM_DIMMS);

  // R5: a stalled offer keeps every field
  p_hold_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(cs_o) && $stable(mr2_o) &&
                               $stable(lvl_o) && $stable(qoff_o) && $stable(train_o)));

  // R3: an accepted register-1 command is followed by register 2 of the same rank
  p_mr2_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && !mr2_o) |=> (valid_o && mr2_o && $stable(cs_o)));

  // R4: output-off only ever comes with leveling, in a register-1 command
  p_qoff_with_lvl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && qoff_o) |-> (lvl_o && !mr2_o && tgt_hit_o));

endmodule

// File: rtl/wlvl_ctl.sv
module wlvl_ctl
  import wlvl_pkg::*;
#(
  parameter int PASS_W    = 2,
  parameter int PREP_GAP  = 40,
  parameter int ODT_WAIT  = 10,
  parameter int TRAIN_LEN = 140,
  parameter int TW        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PASS_W-1:0] pass_i,
  input  logic              walk_fin_i,
  input  logic              empty_raw_i,
  input  logic              empty_lat_i,
  input  logic              tmr_zero_i,
  output logic              go_o,
  output logic              go_mode_o,
  output logic              load_cfg_o,
  output logic              tmr_load_o,
  output logic [TW-1:0]     tmr_val_o,
  output logic              odt_o,
  output logic              train_o,
  output logic [PASS_W-1:0] pass_o,
  output logic              done_o
);

  localparam logic [TW-1:0] LD_PREP  = TW'(PREP_GAP - 1);
  localparam logic [TW-1:0] LD_ODT   = TW'(ODT_WAIT - 1);
  localparam logic [TW-1:0] LD_TRAIN = TW'(TRAIN_LEN - 1);

  seq_state_e        st_q, st_d;
  logic              odt_q, odt_d, trn_q, trn_d, done_q, done_d;
  logic [PASS_W-1:0] pass_q;

  always_comb begin
    st_d       = st_q;
    go_o       = 1'b0;
    go_mode_o  = 1'b0;
    load_cfg_o = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    odt_d      = odt_q;
    trn_d      = trn_q;
    done_d     = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        go_o       = 1'b1;
        go_mode_o  = 1'b1;
        load_cfg_o = 1'b1;
        if (empty_raw_i) begin
          st_d       = ST_GAP_PREP;
          tmr_load_o = 1'b1;
          tmr_val_o  = LD_PREP;
        end else begin
          st_d = ST_WALK_LVL;
        end
      end
      ST_WALK_LVL: if (walk_fin_i) begin
        st_d       = ST_GAP_PREP;
        tmr_load_o = 1'b1;
        tmr_val_o  = LD_PREP;
      end
      ST_GAP_PREP: if (tmr_zero_i) begin
        odt_d      = 1'b1;
        st_d       = ST_ODT_SETTLE;
        tmr_load_o = 1'b1;
        tmr_val_o  = LD_ODT;
      end
      ST_ODT_SETTLE: if (tmr_zero_i) begin
        trn_d      = 1'b1;
        st_d       = ST_TRAIN;
        tmr_load_o = 1'b1;
        tmr_val_o  = LD_TRAIN;
      end
      ST_TRAIN: if (tmr_zero_i) begin
        trn_d = 1'b0;
        st_d  = ST_TRAIN_OFF;
      end
      ST_TRAIN_OFF: begin
        odt_d      = 1'b0;
        st_d       = ST_ODT_DRAIN;
        tmr_load_o = 1'b1;
        tmr_val_o  = LD_ODT;
      end
      ST_ODT_DRAIN: if (tmr_zero_i) begin
        go_o = 1'b1;
        if (empty_lat_i) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_WALK_NORM;
        end
      end
      ST_WALK_NORM: if (walk_fin_i) begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      odt_q  <= 1'b0;
      trn_q  <= 1'b0;
      done_q <= 1'b0;
      pass_q <= '0;
    end else begin
      st_q   <= st_d;
      odt_q  <= odt_d;
      trn_q  <= trn_d;
      done_q <= done_d;
      if (load_cfg_o) pass_q <= pass_i;
    end
  end

  assign odt_o   = odt_q;
  assign train_o = trn_q;
  assign pass_o  = pass_q;
  assign done_o  = done_q;

  // R7: training runs only under termination that was already on
  p_train_under_odt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trn_q) |-> $past(odt_q));
  p_train_needs_odt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trn_q |-> odt_q);
  // R7: pass value frozen through training
  p_pass_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_q && $past(trn_q)) |-> $stable(pass_q));
  // R8: termination leaves one cycle after training
  p_odt_trails_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trn_q) |=> $fell(odt_q));
  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
  import wlvl_pkg::*;
#(
  parameter int NUM_DIMMS = 4,
  parameter int PASS_W    = 2,
  parameter int PREP_GAP  = 40,
  parameter int ODT_WAIT  = 10,
  parameter int TRAIN_LEN = 140,
  localparam int DIMM_W   = $clog2(NUM_DIMMS),
  localparam int CS_W     = DIMM_W + 1,
  localparam int TBL_W    = NUM_DIMMS * RCNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DIMM_W-1:0] tgt_dimm_i,
  input  logic [PASS_W-1:0] pass_i,
  input  logic [TBL_W-1:0]  rank_cnt_i,
  output logic              done_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [CS_W-1:0]   cmd_cs_o,
  output logic              cmd_mr2_o,
  output logic              cmd_level_o,
  output logic              cmd_qoff_o,
  output logic              cmd_train_o,
  output logic              cmd_target_o,
  output logic              phy_odt_en_o,
  output logic              phy_train_en_o,
  output logic [PASS_W-1:0] phy_pass_o
);

  localparam int TMAX = (TRAIN_LEN > PREP_GAP) ?
                        ((TRAIN_LEN > ODT_WAIT) ? TRAIN_LEN : ODT_WAIT) :
                        ((PREP_GAP > ODT_WAIT) ? PREP_GAP : ODT_WAIT);
  localparam int TW   = $clog2(TMAX + 1);

  logic          go, go_mode, load_cfg, walk_fin, empty_raw, empty_lat;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  wlvl_ctl #(
    .PASS_W(PASS_W), .PREP_GAP(PREP_GAP), .ODT_WAIT(ODT_WAIT),
    .TRAIN_LEN(TRAIN_LEN), .TW(TW)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pass_i(pass_i),
    .walk_fin_i(walk_fin), .empty_raw_i(empty_raw), .empty_lat_i(empty_lat),
    .tmr_zero_i(tmr_zero), .go_o(go), .go_mode_o(go_mode),
    .load_cfg_o(load_cfg), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .odt_o(phy_odt_en_o), .train_o(phy_train_en_o), .pass_o(phy_pass_o),
    .done_o(done_o)
  );

  wlvl_walk #(.NUM_DIMMS(NUM_DIMMS), .DIMM_W(DIMM_W), .CS_W(CS_W)) walk_i (
    .clk(clk), .rst_n(rst_n), .go_i(go), .load_i(load_cfg), .mode_i(go_mode),
    .tgt_i(tgt_dimm_i), .tbl_i(rank_cnt_i), .ready_i(cmd_ready_i),
    .valid_o(cmd_valid_o), .cs_o(cmd_cs_o), .mr2_o(cmd_mr2_o),
    .lvl_o(cmd_level_o), .qoff_o(cmd_qoff_o), .train_o(cmd_train_o),
    .tgt_hit_o(cmd_target_o), .fin_o(walk_fin),
    .empty_raw_o(empty_raw), .empty_lat_o(empty_lat)
  );

  wlvl_timer #(.W(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  // R9: the command port is silent while termination is on
  p_quiet_under_odt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_odt_en_o |-> !cmd_valid_o);
  // R4: training flags only appear while the leveling walk runs
  p_lvl_only_training_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_level_o) |-> cmd_train_o);

endmodule

// File: tb/wlvl_seq_tb_top.sv
module wlvl_seq_tb_top;

  typedef logic [7:0] item_t;   // {cs[2:0], mr2, level, qoff, train, target}

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] tgt_dimm_i = '0;
  logic [1:0] pass_i = '0;
  logic [7:0] rank_cnt_i = '0;
  logic       cmd_ready_i = 1'b1;
  logic       done_o, cmd_valid_o, cmd_mr2_o, cmd_level_o, cmd_qoff_o;
  logic       cmd_train_o, cmd_target_o, phy_odt_en_o, phy_train_en_o;
  logic [2:0] cmd_cs_o;
  logic [1:0] phy_pass_o;

  wlvl_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_dimm_i(tgt_dimm_i),
    .pass_i(pass_i), .rank_cnt_i(rank_cnt_i), .done_o(done_o),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i), .cmd_cs_o(cmd_cs_o),
    .cmd_mr2_o(cmd_mr2_o), .cmd_level_o(cmd_level_o), .cmd_qoff_o(cmd_qoff_o),
    .cmd_train_o(cmd_train_o), .cmd_target_o(cmd_target_o),
    .phy_odt_en_o(phy_odt_en_o), .phy_train_en_o(phy_train_en_o),
    .phy_pass_o(phy_pass_o)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  item_t exp_q[$];
  int  stall_mode = 0;
  int  exp_pass = 0;
  int  phase = 3;           // 0 leveling walk, 1 training, 2 restore, 3 idle
  int  ref_edge = 0, odt_rise = 0, train_rise = 0, train_fall = 0;
  int  odt_fall = 0, ref_done = 0, done_cnt = 0, acc_cnt = 0;
  bit  norm_seen = 0, hold_pend = 0, prev_odt = 0, prev_trn = 0, prev_done = 0;
  bit  prev_valid = 0;
  item_t held;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Expected commands for one DIMM, written from the requirement text.
  task automatic push_dimm(input int d, input int tgt, input logic [7:0] tbl, input bit trn);
    int n;
    n = int'(tbl[2*d +: 2]);
    if (n > 2) n = 2;                       // R12
    for (int r = 0; r < n; r++) begin
      bit is_t;
      is_t = (d == tgt);
      exp_q.push_back({3'(2*d + r), 1'b0, trn & is_t, trn & is_t & (r != 0), trn, is_t});
      exp_q.push_back({3'(2*d + r), 1'b1, 1'b0, 1'b0, trn, is_t});
    end
  endtask

  task automatic push_walk(input int tgt, input logic [7:0] tbl, input bit trn);
    push_dimm(tgt, tgt, tbl, trn);
    for (int d = 0; d < 4; d++) if (d != tgt) push_dimm(d, tgt, tbl, trn);
  endtask

  // Monitor: compares accepted commands and measures PHY timing.
  always @(negedge clk) begin
    if (rst_n) begin
      item_t got, e;
      got = {cmd_cs_o, cmd_mr2_o, cmd_level_o, cmd_qoff_o, cmd_train_o, cmd_target_o};
      if (hold_pend)
        check(cmd_valid_o && got == held, "R5 stalled command changed", int'(got), int'(held));
      hold_pend = cmd_valid_o && !cmd_ready_i;
      held = got;
      if (phase == 2 && cmd_valid_o && !prev_valid && !norm_seen) begin
        norm_seen = 1;
        check(cyc == odt_fall + 10, "R9 restore start", cyc - odt_fall, 10);
      end
      if (cmd_valid_o && cmd_ready_i) begin
        acc_cnt++;
        if (exp_q.size() == 0) begin
          check(0, "R2 R11 unexpected command", int'(got), 0);
        end else begin
          e = exp_q.pop_front();
          check(got == e, "R2 R3 R4 command fields", int'(got), int'(e));
        end
        if (phase == 0) ref_edge = cyc + 1;
        if (phase == 2) ref_done = cyc + 1;
      end
      if (phy_odt_en_o && !prev_odt) begin
        check(cyc == ref_edge + 40, "R6 odt rise delay", cyc - ref_edge, 40);
        odt_rise = cyc;
        phase = 1;
      end
      if (phy_train_en_o && !prev_trn) begin
        check(cyc == odt_rise + 10, "R7 train rise delay", cyc - odt_rise, 10);
        check(int'(phy_pass_o) == exp_pass, "R7 pass value", int'(phy_pass_o), exp_pass);
        train_rise = cyc;
      end
      if (!phy_train_en_o && prev_trn) begin
        check(cyc == train_rise + 140, "R8 train width", cyc - train_rise, 140);
        train_fall = cyc;
      end
      if (!phy_odt_en_o && prev_odt) begin
        check(cyc == train_fall + 1, "R8 odt fall", cyc - train_fall, 1);
        odt_fall = cyc;
        ref_done = cyc + 10;
        norm_seen = 0;
        phase = 2;
      end
      if (done_o) begin
        check(!prev_done, "R10 done width", 2, 1);
        check(cyc == ref_done, "R10 done timing", cyc, ref_done);
        check(exp_q.size() == 0, "R2 commands left over", exp_q.size(), 0);
        done_cnt++;
        phase = 3;
      end
      prev_odt = phy_odt_en_o;
      prev_trn = phy_train_en_o;
      prev_done = done_o;
      prev_valid = cmd_valid_o;
    end
  end

  // Ready driver
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cmd_ready_i = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
    end
  end

  task automatic run_case(input int tgt, input logic [7:0] tbl, input int ps,
                          input int stall, input bit poke, input int exp_cmds,
                          input string req);
    int d0;
    stall_mode = stall;
    exp_pass = ps;
    acc_cnt = 0;
    push_walk(tgt, tbl, 1'b1);
    push_walk(tgt, tbl, 1'b0);
    d0 = done_cnt;
    @(posedge clk); #1;
    tgt_dimm_i = 2'(tgt); rank_cnt_i = tbl; pass_i = 2'(ps); start_i = 1'b1;
    ref_edge = cyc + 1;
    phase = 0;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      wait (phy_train_en_o);
      @(posedge clk); #1;
      tgt_dimm_i = 2'd0; rank_cnt_i = 8'hFF; pass_i = 2'd3; start_i = 1'b1;   // R11
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    wait (done_cnt == d0 + 1);
    repeat (poke ? 300 : 20) @(posedge clk);
    check(acc_cnt == exp_cmds, req, acc_cnt, exp_cmds);
    check(done_cnt == d0 + 1, "R10 R11 done count", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check(!cmd_valid_o && !done_o && !phy_odt_en_o && !phy_train_en_o,
          "R1 outputs in reset", 1, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid_o && !done_o && !phy_odt_en_o && !phy_train_en_o,
          "R1 outputs after reset", 1, 0);
    // ranks d0..d3 = 2,2,0,1 ; target 1 ; five ranks
    run_case(1, {2'd1, 2'd0, 2'd2, 2'd2}, 1, 0, 0, 20, "R2 command count");
    // ranks 1,0,3,2 with stalls: count 3 clipped to 2
    run_case(0, {2'd2, 2'd3, 2'd0, 2'd1}, 2, 1, 0, 20, "R12 clipped rank count");
    // busy start ignored
    run_case(3, {2'd2, 2'd0, 2'd1, 2'd0}, 1, 1, 1, 12, "R11 command count");
    // nothing present
    run_case(2, 8'h00, 2, 0, 0, 0, "R6 R10 empty channel count");
    // target absent, others present
    run_case(2, {2'd1, 2'd0, 2'd0, 2'd2}, 3, 1, 0, 12, "R2 absent target count");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule